// File: doc/BRIEF.md
# Dual-slot B-channel serial port

This block carries two 8-bit voice/data bytes across a shared, time-multiplexed serial bus. One bit clock serves both directions. Each channel has its own transmit strobe and its own receive strobe, and the strobes pick the slot. A transmit strobe sends that channel's byte, MSB first, on one serial output. The output carries a separate drive-enable, so the pad can be tri-stated. A receive strobe captures eight serial bits into that channel's parallel holding register.

Everything runs on a fast system clock that oversamples the bus. The bit clock, the strobes, the serial input and the two mode selects each pass through a two-flop synchronizer before any edge is detected. The transmit byte can come from three places: the parallel input, a fixed test pattern, or the byte most recently received on the same channel (loopback). Loopback overrides the pattern.

Top module: `bslot_port`

## Requirements
- R1: When both synchronized transmit strobes are low, `sd_oe` is 0 (the output is released).
- R2: A rising edge on `tx_en[c]` drives `sd_oe`=1 and puts the MSB of channel c's byte on `sd_out`. This takes effect three system clocks after the strobe changes, with no wait for a bit-clock edge.
- R3: After that first bit, the port waits for one falling edge of `bclk`. It then presents the remaining seven bits, MSB first, on the next seven rising edges of `bclk`. `sd_out` changes at no other time.
- R4: Dropping the active strobe before the byte ends returns `sd_oe` to 0.
- R5: If both transmit strobes are high together, the port does not hang. Once both fall, `sd_oe` returns to 0, and the next single-strobe transfer is correct.
- R6: A rising edge on `rx_en[c]` arms capture. The next eight falling edges of `bclk` sample `sd_in`, MSB first. The result appears in slice c of `rx_data` (bits `c*8+7:c*8`) as one update when the eighth bit arrives, and the slice is stable otherwise.
- R7: A capture completes all eight bits even if `rx_en[c]` falls after its rising edge.
- R8: While `loop_n` is 0, a transfer on channel c sends the byte currently held in `rx_data` slice c instead of `tx_data` slice c. Reception continues to update `rx_data`.
- R9: While `loop_n` is 1 and `pat_sel` is 1, a transfer sends `PATTERN` (default 8'h7E). When `loop_n` is 0, loopback wins over `pat_sel`.
- R10: `rx_vld[c]` is a one-cycle pulse, issued exactly once per completed capture, in the cycle the new byte appears.
- R11: The transmit byte is latched at the strobe's rising edge. Later changes of `tx_data` do not alter the byte in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Shared serial bit clock |
| sd_in | input | 1 | Serial receive data |
| loop_n | input | 1 | Active-low loopback select |
| pat_sel | input | 1 | Send the fixed pattern instead of parallel data |
| tx_en | input | NCH | Per-channel transmit strobes |
| rx_en | input | NCH | Per-channel receive strobes |
| tx_data | input | NCH*DW | Parallel transmit bytes, channel c at c*DW |
| sd_out | output | 1 | Serial transmit data |
| sd_oe | output | 1 | Drive enable for sd_out (0 = high impedance) |
| rx_data | output | NCH*DW | Received bytes, channel c at c*DW |
| rx_vld | output | NCH | One-cycle capture-complete pulses |

## Verification
Every bus event takes effect on the third rising system clock after the pin changes: two synchronizer flops, then the edge-detect and action register. The first transmitted bit, each later shift, the drop of the drive-enable, and the update of a received byte with its valid pulse all appear after that same edge. The bench's reference model delays each input snapshot by exactly two clocks and acts on the third. It compares every output at the falling system clock edge, away from the edges where the design updates. Serial bits are also collected at the end of each bit-clock high phase, well after the three-clock window, and compared against whole bytes.

// File: rtl/bslot_pkg.sv
package bslot_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_SHIFT = 2'd2,
    TX_HOLD  = 2'd3
  } tx_st_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bslot_sync.sv
module bslot_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign lvl = stab_q;
endmodule

// File: rtl/bslot_rx.sv
module bslot_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_evt,
  input  logic          bit_evt,
  input  logic          sd,
  output logic [DW-1:0] hold_q,
  output logic          vld_q
);
  localparam int CW = $clog2(DW);

  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] acc_q, acc_n;
  logic [DW-1:0] hold_n;
  logic          vld_n;
  logic [DW-1:0] acc_sh;

  assign acc_sh = {acc_q[DW-2:0], sd};

  always_comb begin
    act_n  = act_q;
    cnt_n  = cnt_q;
    acc_n  = acc_q;
    hold_n = hold_q;
    vld_n  = 1'b0;
    if (arm_evt) begin
      act_n = 1'b1;
      cnt_n = '0;
      acc_n = '0;
    end else if (act_q && bit_evt) begin
      acc_n = acc_sh;
      if (cnt_q == CW'(DW-1)) begin
        hold_n = acc_sh;
        vld_n  = 1'b1;
        act_n  = 1'b0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      hold_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      acc_q  <= acc_n;
      hold_q <= hold_n;
      vld_q  <= vld_n;
    end
  end
endmodule

// File: rtl/bslot_tx.sv
module bslot_tx
  import bslot_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    en_lvl,
  input  logic [NCH-1:0]    en_rise,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic [NCH*DW-1:0] src_bus,
  output logic              sd,
  output logic              oe
);
  localparam int CW  = $clog2(DW);
  localparam int CHW = idx_w(NCH);

  tx_st_e         st_q, st_n;
  logic [CHW-1:0] ch_q, ch_n;
  logic [DW-1:0]  sh_q, sh_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [CHW-1:0] pick;
  logic           start;

  // lowest channel index wins when several strobes rise together
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (en_rise[i]) pick = CHW'(i);
    end
  end

  assign start = |en_rise;

  always_comb begin
    st_n  = st_q;
    ch_n  = ch_q;
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (start) begin
      st_n  = TX_WAIT;
      ch_n  = pick;
      sh_n  = src_bus[pick*DW +: DW];
      cnt_n = CW'(DW-1);
    end else begin
      case (st_q)
        TX_WAIT: begin
          if (!en_lvl[ch_q])  st_n = TX_IDLE;
          else if (bclk_fall) st_n = TX_SHIFT;
        end
        TX_SHIFT: begin
          if (!en_lvl[ch_q]) begin
            st_n = TX_IDLE;
          end else if (bclk_rise) begin
            sh_n  = {sh_q[DW-2:0], 1'b0};
            cnt_n = cnt_q - 1'b1;
            if (cnt_q == CW'(1)) st_n = TX_HOLD;
          end
        end
        TX_HOLD: begin
          if (!en_lvl[ch_q]) st_n = TX_IDLE;
        end
        default: st_n = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      ch_q  <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      ch_q  <= ch_n;
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign sd = sh_q[DW-1];
  assign oe = (st_q != TX_IDLE);
endmodule

// File: rtl/bslot_port.sv
module bslot_port #(
  parameter int             DW      = 8,
  parameter int             NCH     = 2,
  parameter logic [DW-1:0]  PATTERN = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              sd_in,
  input  logic              loop_n,
  input  logic              pat_sel,
  input  logic [NCH-1:0]    tx_en,
  input  logic [NCH-1:0]    rx_en,
  input  logic [NCH*DW-1:0] tx_data,
  output logic              sd_out,
  output logic              sd_oe,
  output logic [NCH*DW-1:0] rx_data,
  output logic [NCH-1:0]    rx_vld
);
  localparam int SW = 4 + 2 * NCH;
  localparam int EW = 1 + 2 * NCH;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  // synchronizers
  logic [SW-1:0] raw, s_lvl;
  assign raw = {rx_en, tx_en, pat_sel, loop_n, sd_in, bclk};

  bslot_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .din   (raw),
    .lvl   (s_lvl)
  );

  logic           bclk_lvl, sd_lvl, loop_lvl, pat_lvl;
  logic [NCH-1:0] ten_lvl, ren_lvl;

  assign bclk_lvl = s_lvl[0];
  assign sd_lvl   = s_lvl[1];
  assign loop_lvl = s_lvl[2];
  assign pat_lvl  = s_lvl[3];
  assign ten_lvl  = s_lvl[4 +: NCH];
  assign ren_lvl  = s_lvl[4 + NCH +: NCH];

  // edge detection on the synchronized strobes and bit clock
  logic [EW-1:0]  evt_cur, evt_prv, evt_rise;
  logic           bclk_rise, bclk_fall;
  logic [NCH-1:0] ten_rise, ren_rise;

  assign evt_cur = {ren_lvl, ten_lvl, bclk_lvl};

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) evt_prv <= '0;
    else          evt_prv <= evt_cur;
  end

  assign evt_rise  = evt_cur & ~evt_prv;
  assign bclk_rise = evt_rise[0];
  assign bclk_fall = evt_prv[0] & ~bclk_lvl;
  assign ten_rise  = evt_rise[1 +: NCH];
  assign ren_rise  = evt_rise[1 + NCH +: NCH];

  // per-channel receive and source selection
  logic [NCH*DW-1:0] src_bus;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    bslot_rx #(.DW(DW)) u_rx (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .arm_evt (ren_rise[g]),
      .bit_evt (bclk_fall),
      .sd      (sd_lvl),
      .hold_q  (rx_data[g*DW +: DW]),
      .vld_q   (rx_vld[g])
    );

    // loopback outranks the pattern, which outranks parallel data
    assign src_bus[g*DW +: DW] = !loop_lvl ? rx_data[g*DW +: DW]
                               : (pat_lvl ? PATTERN : tx_data[g*DW +: DW]);
  end

  bslot_tx #(.DW(DW), .NCH(NCH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .en_lvl    (ten_lvl),
    .en_rise   (ten_rise),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .src_bus   (src_bus),
    .sd        (sd_out),
    .oe        (sd_oe)
  );
endmodule

// File: rtl/bslot_port_chk.sv
module bslot_port_chk #(
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_out,
  input logic              sd_oe,
  input logic [NCH*DW-1:0] rx_data,
  input logic [NCH-1:0]    rx_vld,
  input logic [NCH-1:0]    ten_lvl,
  input logic [NCH-1:0]    ten_rise,
  input logic              bclk_rise,
  input logic              loop_lvl
);
  // R1
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ten_lvl == '0) |=> !sd_oe);

  // R2
  start_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ten_rise) |=> sd_oe);

  // R3
  out_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|ten_rise) && !bclk_rise) |=> $stable(sd_out));

  // R8
  loop_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ten_rise[0] && !loop_lvl) |=> (sd_out == $past(rx_data[DW-1])));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R10
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld[g] |=> !rx_vld[g]);

    // R6
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_vld[g] |-> $stable(rx_data[g*DW +: DW]));
  end
endmodule

bind bslot_port bslot_port_chk #(.DW(DW), .NCH(NCH)) u_chk (.*);

// File: tb/bslot_port_bench.sv
module bslot_port_bench;
  localparam logic [7:0] PAT = 8'h7E;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk, sd_in, loop_n, pat_sel;
  logic [1:0]  tx_en, rx_en;
  logic [15:0] tx_data;
  logic        sd_out, sd_oe;
  logic [15:0] rx_data;
  logic [1:0]  rx_vld;

  always #5 clk = ~clk;

  bslot_port u_bslot_port (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .sd_in(sd_in), .loop_n(loop_n),
    .pat_sel(pat_sel), .tx_en(tx_en), .rx_en(rx_en), .tx_data(tx_data),
    .sd_out(sd_out), .sd_oe(sd_oe), .rx_data(rx_data), .rx_vld(rx_vld)
  );

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";
  bit    both_mode = 1'b0;
  int    vcount [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: inputs seen two clocks late, acted on the third
  logic [7:0] h0, h1, h2;
  bit         m_act, m_wait;
  int         m_ch, m_idx;
  logic [7:0] m_byte;
  bit         m_arm [2];
  int         m_cnt [2];
  logic [7:0] m_acc [2];
  logic [7:0] m_buf [2];
  bit         m_vld [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = '0; h1 = '0; h2 = '0;
      m_act = 0; m_wait = 0; m_ch = 0; m_idx = 7; m_byte = '0;
      for (int c = 0; c < 2; c++) begin
        m_arm[c] = 0; m_cnt[c] = 0; m_acc[c] = '0; m_buf[c] = '0; m_vld[c] = 0;
      end
    end else begin
      logic [7:0] lv, pv;
      bit brise, bfall;
      logic [1:0] trise, rrise;
      lv = h1; pv = h2;
      brise = lv[0] & ~pv[0];
      bfall = pv[0] & ~lv[0];
      trise = lv[5:4] & ~pv[5:4];
      rrise = lv[7:6] & ~pv[7:6];
      if (trise != 0) begin
        int c;
        c = trise[0] ? 0 : 1;
        m_act = 1; m_wait = 1; m_ch = c; m_idx = 7;
        m_byte = !lv[2] ? m_buf[c] : (lv[3] ? PAT : tx_data[c*8 +: 8]);
      end else if (m_act) begin
        if (!lv[4 + m_ch]) m_act = 0;
        else if (m_wait) begin
          if (bfall) m_wait = 0;
        end else if (brise && m_idx > 0) m_idx--;
      end
      for (int c = 0; c < 2; c++) begin
        m_vld[c] = 0;
        if (rrise[c]) begin
          m_arm[c] = 1; m_cnt[c] = 0; m_acc[c] = '0;
        end else if (m_arm[c] && bfall) begin
          m_acc[c] = {m_acc[c][6:0], lv[1]};
          m_cnt[c]++;
          if (m_cnt[c] == 8) begin
            m_buf[c] = m_acc[c]; m_vld[c] = 1; m_arm[c] = 0;
          end
        end
      end
      h2 = h1; h1 = h0;
      h0 = {rx_en, tx_en, pat_sel, loop_n, sd_in, bclk};
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !both_mode) begin
      chk(sd_oe == m_act, {"R1/R4 ", cur_req}, "sd_oe", sd_oe, m_act);
      if (m_act)
        chk(sd_out == m_byte[m_idx], {"R2/R3 ", cur_req}, "sd_out", sd_out, m_byte[m_idx]);
      for (int c = 0; c < 2; c++) begin
        chk(rx_data[c*8 +: 8] == m_buf[c], "R6", "rx_data", rx_data[c*8 +: 8], m_buf[c]);
        chk(rx_vld[c] == m_vld[c], "R10", "rx_vld", rx_vld[c], m_vld[c]);
      end
    end
    if (rst_n) for (int c = 0; c < 2; c++) if (rx_vld[c]) vcount[c]++;
  end

  // one 8-bit slot; sd_out is sampled at the end of each bit-clock high phase
  task automatic xfer(input int c, input bit te, input bit re, input logic [7:0] din,
                      input int rdrop, input int tdrop, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bclk = 1'b1; sd_in = din[7-i];
      if (i == 0) begin
        if (te) tx_en[c] = 1'b1;
        if (re) rx_en[c] = 1'b1;
      end
      if (i == tdrop) tx_en[c] = 1'b0;
      repeat (7) @(negedge clk);
      got = {got[6:0], sd_out};
      @(negedge clk);
      bclk = 1'b0;
      if (i == rdrop) rx_en[c] = 1'b0;
      repeat (7) @(negedge clk);
    end
    @(negedge clk);
    tx_en[c] = 1'b0; rx_en[c] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int v0;
    vcount[0] = 0; vcount[1] = 0;
    rst_n = 1'b0; bclk = 0; sd_in = 0; loop_n = 1; pat_sel = 0;
    tx_en = '0; rx_en = '0; tx_data = 16'h81A5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    chk(sd_oe == 1'b0, "R1", "reset sd_oe", sd_oe, 0);
    chk(rx_data == 16'h0, "R6", "reset rx_data", rx_data, 0);
    chk(rx_vld == 2'b00, "R10", "reset rx_vld", rx_vld, 0);

    cur_req = "R2";
    v0 = vcount[0];
    xfer(0, 1, 1, 8'h3C, 99, 99, got);
    chk(got == 8'hA5, "R3", "ch0 serial byte", got, 8'hA5);
    chk(rx_data[7:0] == 8'h3C, "R6", "ch0 capture", rx_data[7:0], 8'h3C);
    chk(vcount[0] - v0 == 1, "R10", "ch0 pulse count", vcount[0] - v0, 1);

    xfer(1, 1, 1, 8'hE7, 99, 99, got);
    chk(got == 8'h81, "R3", "ch1 serial byte", got, 8'h81);
    chk(rx_data[15:8] == 8'hE7, "R6", "ch1 capture", rx_data[15:8], 8'hE7);

    cur_req = "R11";
    fork
      xfer(0, 1, 0, 8'h00, 99, 99, got);
      begin repeat (30) @(negedge clk); tx_data[7:0] = 8'h0F; end
    join
    chk(got == 8'hA5, "R11", "latched byte", got, 8'hA5);

    cur_req = "R7";
    xfer(1, 0, 1, 8'h96, 1, 99, got);
    chk(rx_data[15:8] == 8'h96, "R7", "early-drop capture", rx_data[15:8], 8'h96);

    cur_req = "R4";
    xfer(0, 1, 0, 8'h00, 99, 3, got);
    chk(sd_oe == 1'b0, "R4", "released after drop", sd_oe, 0);

    cur_req = "R8";
    loop_n = 1'b0;
    repeat (6) @(negedge clk);
    xfer(1, 1, 1, 8'h4B, 99, 99, got);
    chk(got == 8'h96, "R8", "loopback byte", got, 8'h96);
    chk(rx_data[15:8] == 8'h4B, "R8", "rx during loopback", rx_data[15:8], 8'h4B);

    cur_req = "R9";
    loop_n = 1'b1; pat_sel = 1'b1;
    repeat (6) @(negedge clk);
    xfer(0, 1, 0, 8'h00, 99, 99, got);
    chk(got == PAT, "R9", "pattern byte", got, PAT);
    loop_n = 1'b0;
    repeat (6) @(negedge clk);
    xfer(0, 1, 0, 8'h00, 99, 99, got);
    chk(got == 8'h3C, "R9", "loopback over pattern", got, 8'h3C);

    cur_req = "R5";
    loop_n = 1'b1; pat_sel = 1'b0;
    both_mode = 1'b1;
    repeat (4) @(negedge clk);
    tx_en = 2'b11;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); bclk = ~bclk;
      repeat (7) @(negedge clk);
    end
    tx_en = 2'b00; bclk = 1'b0;
    repeat (8) @(negedge clk);
    chk(sd_oe == 1'b0, "R5", "released after both", sd_oe, 0);
    both_mode = 1'b0;
    xfer(1, 1, 0, 8'h00, 99, 99, got);
    chk(got == 8'h81, "R5", "transfer after both", got, 8'h81);

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule